// File: doc/BRIEF.md
# Single-Slot Bypass Queue

This block is a queue with room for one element and a parameterized data width. Within one clock cycle its operations take effect as though a push happened first, then a look at the head, then a pop, and then a flush. A push into an empty queue therefore shows up on the head output in that same cycle. It can also be popped in that same cycle, so an empty queue behaves like a wire between producer and consumer.

The producer offers data with a valid/ready handshake on the push side. The consumer sees a combinational head value with a valid flag and takes it by raising its ready input. A synchronous flush input empties the queue at the next clock edge. The slot is written only when a pushed element is not taken in the same cycle.

Top module: `bypass_slot_fifo`

## Requirements
- R1: After reset the slot is empty: push_ready is 1, and pop_valid is 0 while push_valid is 0.
- R2: push_ready is 1 exactly when the slot holds no element, regardless of pop_ready in the same cycle; a full slot refuses a push even while it is being popped.
- R3: With the slot empty and push_valid at 1, pop_valid is 1 and pop_data equals push_data in that same cycle.
- R4: With the slot empty, push_valid and pop_ready both at 1 and flush at 0, the element passes straight through and the slot is still empty in the next cycle.
- R5: A push accepted with pop_ready at 0 and flush at 0 is stored: in the next cycle pop_valid is 1, pop_data is the pushed value and push_ready is 0.
- R6: While the slot holds an element that is not popped or flushed, pop_valid stays 1 and pop_data stays that element, whatever push_data carries.
- R7: A pop of a stored element (pop_valid and pop_ready both 1) leaves the slot empty in the next cycle.
- R8: A flush in the same cycle as a push discards the pushed value: the slot is empty in the next cycle.
- R9: A flush in the same cycle as a pop of a stored element leaves the slot empty in the next cycle.
- R10: Elements leave in the order they were pushed across back-to-back transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous flush; slot empty after the edge |
| push_valid | input | 1 | Producer offers an element |
| push_data | input | DATA_W | Element offered by the producer |
| push_ready | output | 1 | Slot can accept a push this cycle |
| pop_valid | output | 1 | Head element is available this cycle |
| pop_data | output | DATA_W | Head element (stored or bypassed) |
| pop_ready | input | 1 | Consumer takes the head element |

## Verification
The bench targets the same-cycle bypass from an empty slot. A design with a registered head would show pop_valid one cycle late, and one that wrote the slot anyway would show a stale element after a pass-through. It offers pushes to a full slot both with and without a pop in the same cycle. A design that let the pop open the push side would drop or overwrite data there. Flush is raised together with a push and together with a pop to catch a design that lets the push win. A run of back-to-back transfers with changing data shows any reordering or repeated element.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  // Next occupancy following push -> head -> pop -> flush ordering.
  function automatic logic occ_next(input logic full, input logic push_fire,
                                    input logic pop_fire, input logic clr);
    logic nxt;
    nxt = full;
    if (push_fire) nxt = 1'b1;
    if (pop_fire)  nxt = 1'b0;
    if (clr)       nxt = 1'b0;
    return nxt;
  endfunction

  // Slot is written only when a pushed element survives the cycle.
  function automatic logic slot_write(input logic push_fire, input logic pop_fire,
                                      input logic clr);
    return push_fire & ~pop_fire & ~clr;
  endfunction

endpackage

// File: rtl/bsf_occupancy.sv
module bsf_occupancy
  import bsf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_fire,
  input  logic pop_fire,
  input  logic clr,
  output logic full_o
);

  logic full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= occ_next(full_q, push_fire, pop_fire, clr);
  end

  assign full_o = full_q;

  // A full slot cannot see a push fire (push only into empty).
  assert_no_push_into_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !push_fire);

  // Flush empties the slot at the next edge.
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !full_q);

endmodule

// File: rtl/bsf_store.sv
module bsf_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     slot_q <= '0;
    else if (wr_en) slot_q <= wr_data;
  end

  assign q = slot_q;

  // Without a write the slot keeps its value.
  assert_slot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(slot_q));

endmodule

// File: rtl/bsf_view.sv
module bsf_view #(
  parameter int DATA_W = 8
) (
  input  logic              full,
  input  logic [DATA_W-1:0] slot_q,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              head_valid,
  output logic [DATA_W-1:0] head_data
);

  always_comb begin
    head_valid = full | push_valid;
    head_data  = full ? slot_q : push_data;
  end

endmodule

// File: rtl/bypass_slot_fifo.sv
module bypass_slot_fifo #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  input  logic              pop_ready
);
  import bsf_pkg::*;

  // Named internal events for the assertions.
  logic              full_w;
  logic              push_fire;
  logic              pop_fire;
  logic              slot_wr;
  logic [DATA_W-1:0] slot_q;

  assign push_ready = ~full_w;
  assign push_fire  = push_valid & push_ready;
  assign pop_fire   = pop_valid & pop_ready;
  assign slot_wr    = slot_write(push_fire, pop_fire, flush);

  bsf_occupancy u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .clr       (flush),
    .full_o    (full_w)
  );

  bsf_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (slot_wr),
    .wr_data (push_data),
    .q       (slot_q)
  );

  bsf_view #(.DATA_W(DATA_W)) u_view (
    .full       (full_w),
    .slot_q     (slot_q),
    .push_valid (push_valid),
    .push_data  (push_data),
    .head_valid (pop_valid),
    .head_data  (pop_data)
  );

  assert_bypass_same_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ready && push_valid) |-> (pop_valid && pop_data == push_data));

  assert_passthrough_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ready && push_valid && pop_ready) |=> push_ready);

  assert_push_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ready && push_valid && !pop_ready && !flush) |=>
      (!push_ready && pop_valid && pop_data == $past(push_data)));

  assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && !pop_ready && !flush) |=> (pop_valid && $stable(pop_data)));

  assert_pop_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && pop_ready) |=> push_ready);

  assert_flush_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && pop_valid && pop_ready) |=> (push_ready && !u_occ.full_o));

endmodule

// File: tb/bypass_slot_fifo_tb_top.sv
module bypass_slot_fifo_tb_top;

  localparam int DATA_W = 8;
  localparam int NVEC   = 19;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              push_valid = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic              push_ready;
  logic              pop_valid;
  logic [DATA_W-1:0] pop_data;
  logic              pop_ready = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bypass_slot_fifo #(.DATA_W(DATA_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .push_valid (push_valid),
    .push_data  (push_data),
    .push_ready (push_ready),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .pop_ready  (pop_ready)
  );

  // {push_valid, push_data, pop_ready, flush, exp_push_ready, exp_pop_valid, exp_pop_data}
  localparam logic [20:0] VECS [0:NVEC-1] = '{
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // 0  empty after reset
    {1'b1, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5},  // 1  bypass + same-cycle pop
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // 2  still empty
    {1'b1, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C},  // 3  push, stored
    {1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C},  // 4  refused, head held
    {1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C},  // 5  refused even while popping
    {1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 1'b1, 8'h77},  // 6  slot emptied by pop
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h77},  // 7  pop stored
    {1'b1, 8'h11, 1'b1, 1'b0, 1'b1, 1'b1, 8'h11},  // 8  back-to-back stream
    {1'b1, 8'h22, 1'b1, 1'b0, 1'b1, 1'b1, 8'h22},  // 9
    {1'b1, 8'h99, 1'b0, 1'b1, 1'b1, 1'b1, 8'h99},  // 10 flush with push
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // 11 push discarded
    {1'b1, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A},  // 12 push, stored
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h5A},  // 13 flush with pop
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // 14 empty
    {1'b1, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3},  // 15 push, stored
    {1'b1, 8'hEE, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3},  // 16 hold against new push_data
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC3},  // 17 lone flush
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}   // 18 empty
  };

  function automatic string tag_of(input int row);
    case (row)
      0:                 return "R1";
      1:                 return "R3";
      2:                 return "R4";
      3, 6:              return "R5";
      4, 5:              return "R2";
      7:                 return "R7";
      8, 9:              return "R10";
      10, 11:            return "R8";
      13, 14:            return "R9";
      16, 17:            return "R6";
      default:           return "R5";
    endcase
  endfunction

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_data(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s pop_data actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic pv, input logic [DATA_W-1:0] pd, input logic pr, input logic fl);
    @(negedge clk);
    push_valid = pv; push_data = pd; pop_ready = pr; flush = fl;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Vector table walk.
    for (int i = 0; i < NVEC; i++) begin
      logic [20:0] v;
      v = VECS[i];
      drive(v[20], v[19:12], v[11], v[10]);
      check_bit(tag_of(i), "push_ready", push_ready, v[9]);
      check_bit(tag_of(i), "pop_valid", pop_valid, v[8]);
      if (v[8]) check_data(tag_of(i), pop_data, v[7:0]);
    end

    // R10: stored/bypassed stream with a slow consumer; one-deep reference model.
    begin
      logic              mfull;
      logic [DATA_W-1:0] mdata;
      logic [DATA_W-1:0] nxt;
      mfull = 1'b0; mdata = '0; nxt = 8'h40;
      for (int c = 0; c < 24; c++) begin
        logic pr;
        pr = (c % 3) != 0;
        drive(1'b1, nxt, pr, 1'b0);
        check_bit("R2", "push_ready", push_ready, !mfull);
        check_bit("R10", "pop_valid", pop_valid, 1'b1);
        check_data("R10", pop_data, mfull ? mdata : nxt);
        if (!mfull) begin
          if (!pr) begin mfull = 1'b1; mdata = nxt; end
          nxt = nxt + 8'd7;
        end else if (pr) begin
          mfull = 1'b0;
        end
      end
    end

    // R1: reset while holding an element.
    drive(1'b1, 8'hAA, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b0, 1'b0);
    check_bit("R5", "pop_valid", pop_valid, 1'b1);
    rst_n = 1'b0;
    drive(1'b0, 8'h00, 1'b0, 1'b0);
    check_bit("R1", "push_ready", push_ready, 1'b1);
    check_bit("R1", "pop_valid", pop_valid, 1'b0);
    rst_n = 1'b1;
    drive(1'b0, 8'h00, 1'b0, 1'b0);
    check_bit("R1", "pop_valid", pop_valid, 1'b0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule